// File: doc/BRIEF.md
# Write-After-Write Decode Scoreboard

This unit sits in the decode stage of an in-order pipeline whose execute path forks after register read into a single-cycle ALU and a fixed-latency divider. Because the two paths finish at different times, a younger instruction sent down the short path could write its destination before an older, slower instruction writes that same register. The final register value would then be wrong. The unit tracks every destination register that has a write in flight and holds a younger instruction in decode until its write is certain to land after the write already pending.

Each architectural register except register 0 has a pending flag and a down-counter. The counter gives the number of cycles left before the tracked write completes. An issue loads the counter with the latency of the chosen unit, minus one. The counter then decrements every cycle until it reaches zero. The matching writeback clears the flag. A writeback that arrives while the counter is still above zero belongs to an older, superseded write and is discarded.

The decode stage sees `stall_o` in the same cycle that it presents a request. The request issues when it is valid and not stalled.

Top module: `waw_scoreboard`

## Requirements
- R1: After reset every bit of `pend_o` is 0, and `stall_o` is 0.
- R2: `issue_o` is high exactly when `dec_valid_i` is high and `stall_o` is low. `stall_o` is never high while `dec_valid_i` is low. A stalled request changes no scoreboard state.
- R3: An issue to a nonzero register sets that register's `pend_o` bit from the next cycle onward.
- R4: The unit code `dec_unit_i` is 0 for the ALU (latency 1) and 1 for the divider (latency 8). A request stalls when its destination is pending and the cycles left on that write are at least its own unit's latency. An ALU request to a register written by a divide issued in cycle t therefore stalls in cycles t+1 through t+7 and issues in cycle t+8.
- R5: No stall occurs for a divide after a divide, a divide after an ALU op, or an ALU op after an ALU op to the same register, when each request is presented in the cycle after the earlier one.
- R6: A request whose destination differs from every pending register never stalls.
- R7: A writeback to a register whose counter is zero clears its `pend_o` bit from the next cycle. A writeback while the counter is above zero is ignored, and the bit stays set.
- R8: When a writeback and a new issue target the same register in the same cycle, the register stays pending.
- R9: Register 0 is never tracked. Its `pend_o` bit stays 0, and a request to it never stalls.
- R10: The ALU and divider writeback inputs act independently. Both may clear different registers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dec_valid_i | input | 1 | Decode presents an instruction to issue |
| dec_unit_i | input | 1 | Target unit: 0 ALU, 1 divider |
| dec_rd_i | input | 5 | Destination register of the decode instruction |
| stall_o | output | 1 | Hold the decode instruction this cycle |
| issue_o | output | 1 | Decode instruction leaves this cycle |
| alu_wb_valid_i | input | 1 | ALU writeback completes this cycle |
| alu_wb_rd_i | input | 5 | ALU writeback register |
| div_wb_valid_i | input | 1 | Divider writeback completes this cycle |
| div_wb_rd_i | input | 5 | Divider writeback register |
| pend_o | output | 32 | Per-register pending-write flags |

## Verification
The main corner is the edge of the stall window. The ALU request must still stall when exactly one cycle remains and must issue in the cycle after that. A design off by one in the load value or in the comparison would release it a cycle early, which reorders the writes, or hold it a cycle too long. The bench sends a stale writeback in the middle of a divide's window. A design that cleared on any writeback would drop the flag too early. The bench also makes a completion and a re-issue meet on one register. A design where the clear wins would lose track of the new write. Register 0 and a divide following a divide are checked to confirm that no stall occurs. A comparator using the wrong unit's latency would stall those requests for no reason.

// File: rtl/waw_sb_pkg.sv
package waw_sb_pkg;
  typedef enum logic {
    UNIT_ALU = 1'b0,
    UNIT_DIV = 1'b1
  } unit_e;
endpackage

// File: rtl/waw_sb_entry.sv
module waw_sb_entry #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic [CNT_W-1:0] set_cnt_i,
  input  logic             clr_i,
  output logic             pend_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             pend_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (set_i) begin
      pend_q <= 1'b1;
      cnt_q  <= set_cnt_i;
    end else begin
      // only the write whose window has run out may retire the entry
      if (clr_i && cnt_q == '0) pend_q <= 1'b0;
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign pend_o = pend_q;
  assign cnt_o  = cnt_q;

  a_r7_countdown: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  a_r7_stale_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && cnt_q != '0) |=> pend_q);
  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && clr_i && cnt_q == '0 && !set_i) |=> !pend_q);
  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> pend_q);
  a_r3_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_q |-> cnt_q == '0);
endmodule

// File: rtl/waw_sb_clr_dec.sv
module waw_sb_clr_dec #(
  parameter int unsigned NUM_REGS = 32,
  localparam int unsigned REG_W = $clog2(NUM_REGS)
) (
  input  logic                alu_valid_i,
  input  logic [REG_W-1:0]    alu_rd_i,
  input  logic                div_valid_i,
  input  logic [REG_W-1:0]    div_rd_i,
  output logic [NUM_REGS-1:0] clr_o
);
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_clr
    assign clr_o[r] = (alu_valid_i && alu_rd_i == REG_W'(r)) ||
                      (div_valid_i && div_rd_i == REG_W'(r));
  end
endmodule

// File: rtl/waw_sb_lookup.sv
module waw_sb_lookup
  import waw_sb_pkg::*;
#(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned ALU_LAT  = 1,
  parameter int unsigned DIV_LAT  = 8,
  localparam int unsigned REG_W = $clog2(NUM_REGS),
  localparam int unsigned CNT_W = $clog2(DIV_LAT + 1)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           valid_i,
  input  unit_e                          unit_i,
  input  logic [REG_W-1:0]               rd_i,
  input  logic [NUM_REGS-1:0]            pend_i,
  input  logic [NUM_REGS-1:0][CNT_W-1:0] cnt_i,
  output logic                           stall_o,
  output logic [CNT_W-1:0]               load_cnt_o
);
  logic [CNT_W:0]   need_lat;
  logic [CNT_W-1:0] left;
  logic             hit;

  always_comb begin
    need_lat   = (unit_i == UNIT_DIV) ? (CNT_W+1)'(DIV_LAT) : (CNT_W+1)'(ALU_LAT);
    load_cnt_o = (unit_i == UNIT_DIV) ? CNT_W'(DIV_LAT - 1) : CNT_W'(ALU_LAT - 1);
    hit        = (rd_i != '0) && pend_i[rd_i];
    left       = cnt_i[rd_i];
    // stall unless the new write is sure to land after the pending one
    stall_o    = valid_i && hit && ({1'b0, left} >= need_lat);
  end

  a_r4_order_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !stall_o && rd_i != '0 && pend_i[rd_i]) |-> ({1'b0, cnt_i[rd_i]} < need_lat));
  a_r6_no_false_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> pend_i[rd_i]);
endmodule

// File: rtl/waw_scoreboard.sv
module waw_scoreboard
  import waw_sb_pkg::*;
#(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned ALU_LAT  = 1,
  parameter int unsigned DIV_LAT  = 8,
  localparam int unsigned REG_W = $clog2(NUM_REGS),
  localparam int unsigned CNT_W = $clog2(DIV_LAT + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                dec_valid_i,
  input  logic                dec_unit_i,
  input  logic [REG_W-1:0]    dec_rd_i,
  output logic                stall_o,
  output logic                issue_o,
  input  logic                alu_wb_valid_i,
  input  logic [REG_W-1:0]    alu_wb_rd_i,
  input  logic                div_wb_valid_i,
  input  logic [REG_W-1:0]    div_wb_rd_i,
  output logic [NUM_REGS-1:0] pend_o
);
  logic [NUM_REGS-1:0][CNT_W-1:0] cnt;
  logic [NUM_REGS-1:0]            clr;
  logic [CNT_W-1:0]               load_cnt;
  unit_e                          unit;

  assign unit    = unit_e'(dec_unit_i);
  assign issue_o = dec_valid_i && !stall_o;

  waw_sb_lookup #(
    .NUM_REGS(NUM_REGS), .ALU_LAT(ALU_LAT), .DIV_LAT(DIV_LAT)
  ) u_lookup (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (dec_valid_i),
    .unit_i     (unit),
    .rd_i       (dec_rd_i),
    .pend_i     (pend_o),
    .cnt_i      (cnt),
    .stall_o    (stall_o),
    .load_cnt_o (load_cnt)
  );

  waw_sb_clr_dec #(.NUM_REGS(NUM_REGS)) u_clr_dec (
    .alu_valid_i (alu_wb_valid_i),
    .alu_rd_i    (alu_wb_rd_i),
    .div_valid_i (div_wb_valid_i),
    .div_rd_i    (div_wb_rd_i),
    .clr_o       (clr)
  );

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    if (r == 0) begin : g_zero
      assign pend_o[r] = 1'b0;
      assign cnt[r]    = '0;
    end else begin : g_entry
      waw_sb_entry #(.CNT_W(CNT_W)) u_entry (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .set_i     (issue_o && dec_rd_i == REG_W'(r)),
        .set_cnt_i (load_cnt),
        .clr_i     (clr[r]),
        .pend_o    (pend_o[r]),
        .cnt_o     (cnt[r])
      );
    end
  end

  a_r2_stall_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> dec_valid_i);
  a_r3_issue_marks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o && dec_rd_i != '0) |=> pend_o[$past(dec_rd_i)]);
  a_r9_zero_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_rd_i == '0) |-> !stall_o);
  a_r2_stall_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && !clr[dec_rd_i]) |=> pend_o[$past(dec_rd_i)]);
endmodule

// File: tb/waw_scoreboard_test.sv
module waw_scoreboard_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        dec_valid_i = 1'b0;
  logic        dec_unit_i = 1'b0;
  logic [4:0]  dec_rd_i = '0;
  logic        stall_o, issue_o;
  logic        alu_wb_valid_i = 1'b0;
  logic [4:0]  alu_wb_rd_i = '0;
  logic        div_wb_valid_i = 1'b0;
  logic [4:0]  div_wb_rd_i = '0;
  logic [31:0] pend_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  localparam logic ALU = 1'b0;
  localparam logic DIV = 1'b1;

  always #10 clk_i = ~clk_i;

  waw_scoreboard uut (
    .clk_i, .rst_ni, .dec_valid_i, .dec_unit_i, .dec_rd_i, .stall_o, .issue_o,
    .alu_wb_valid_i, .alu_wb_rd_i, .div_wb_valid_i, .div_wb_rd_i, .pend_o
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, settle, caller then checks combinational outputs
  task automatic cyc(logic v, logic u, logic [4:0] rd,
                     logic av = 0, logic [4:0] ard = 0,
                     logic dv = 0, logic [4:0] drd = 0);
    @(negedge clk_i);
    dec_valid_i = v; dec_unit_i = u; dec_rd_i = rd;
    alu_wb_valid_i = av; alu_wb_rd_i = ard;
    div_wb_valid_i = dv; div_wb_rd_i = drd;
    #2;
  endtask

  task automatic t_reset;
    cyc(0, ALU, 0);
    chk("R1 pend", pend_o, 32'h0);
    chk("R1 stall", {31'b0, stall_o}, 0);
  endtask

  task automatic t_div_then_alu;
    cyc(1, DIV, 5);
    chk("R2 issue div", {31'b0, issue_o}, 1);
    for (int k = 1; k <= 7; k++) begin
      cyc(1, ALU, 5);
      chk("R4 stall window", {31'b0, stall_o}, 1);
      chk("R2 no issue while stalled", {31'b0, issue_o}, 0);
    end
    cyc(1, ALU, 5, 0, 0, 1, 5);
    chk("R4 release", {31'b0, stall_o}, 0);
    chk("R4 issue", {31'b0, issue_o}, 1);
    cyc(0, ALU, 0, 1, 5);
    chk("R8 set wins", {31'b0, pend_o[5]}, 1);
    cyc(0, ALU, 0);
    chk("R7 cleared", {31'b0, pend_o[5]}, 0);
  endtask

  task automatic t_stale_wb;
    cyc(1, DIV, 6);
    chk("R3 before", {31'b0, pend_o[6]}, 0);
    cyc(0, ALU, 0);
    chk("R3 set", {31'b0, pend_o[6]}, 1);
    cyc(0, ALU, 0, 1, 6);
    cyc(0, ALU, 0);
    chk("R7 stale ignored", {31'b0, pend_o[6]}, 1);
    cyc(0, ALU, 6);
    chk("R2 no req no stall", {31'b0, stall_o}, 0);
    chk("R2 no req no issue", {31'b0, issue_o}, 0);
    for (int k = 5; k <= 7; k++) cyc(0, ALU, 0);
    cyc(0, ALU, 0, 0, 0, 1, 6);
    cyc(0, ALU, 0);
    chk("R7 real clear", {31'b0, pend_o[6]}, 0);
  endtask

  task automatic t_no_stall_pairs;
    cyc(1, DIV, 7);
    cyc(1, DIV, 7);
    chk("R5 div after div", {31'b0, stall_o}, 0);
    cyc(1, ALU, 8);
    cyc(1, ALU, 8);
    chk("R5 alu after alu", {31'b0, stall_o}, 0);
    cyc(1, DIV, 8);
    chk("R5 div after alu", {31'b0, stall_o}, 0);
    cyc(1, DIV, 9);
    cyc(1, ALU, 10);
    chk("R6 other reg", {31'b0, stall_o}, 0);
  endtask

  task automatic t_zero;
    cyc(1, DIV, 0);
    cyc(1, ALU, 0);
    chk("R9 no stall", {31'b0, stall_o}, 0);
    cyc(0, ALU, 0);
    chk("R9 untracked", {31'b0, pend_o[0]}, 0);
  endtask

  task automatic t_dual_wb;
    cyc(1, ALU, 11);
    cyc(1, DIV, 12);
    for (int k = 2; k <= 8; k++) cyc(0, ALU, 0);
    chk("R10 both pending", {30'b0, pend_o[12], pend_o[11]}, 2'b11);
    cyc(0, ALU, 0, 1, 11, 1, 12);
    cyc(0, ALU, 0);
    chk("R10 both cleared", {30'b0, pend_o[12], pend_o[11]}, 2'b00);
  endtask

  initial begin
    #25 rst_ni = 1'b1;
    t_reset();
    t_div_then_alu();
    t_stale_wb();
    t_no_stall_pairs();
    t_zero();
    t_dual_wb();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule